// File: doc/BRIEF.md
# UART Receive FIFO Controller

This block is the receive-side buffer control of a 16550-style serial port. Bytes recovered by a separate deserialiser arrive on a valid/ready stream together with a flag that marks a received break. They are queued in a 16-entry buffer. The CPU pops them through a read strobe and clears sticky error bits through a line-status read strobe. A FIFO control write port selects buffered or single-byte mode, flushes the buffers and picks an interrupt trigger level.

In buffered mode the block keeps a character-timeout counter. The counter is clocked by a 16x baud enable tick, and its limit is four character times, where a character time follows the frame format inputs. In single-byte mode a lone holding register takes the place of the queue.

The receive stream cannot be held off, because the line keeps delivering bits whether or not there is space. `rx_ready` is therefore always high, and a lack of space shows up as the overrun bit rather than as back-pressure. A byte is taken in every cycle in which `rx_valid` is high.

Top module: `uart_rxq`

## Requirements
- R1: In buffered mode (retained control bit 0 set) received bytes are queued up to 16 deep and read back oldest first. `fifo_count` gives the number held, and `rd_data` shows the oldest byte in the cycle a read is issued.
- R2: `trig_level` is decoded from control bits 7:6: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14.
- R3: A byte arriving while 16 bytes are held is discarded and the stored bytes stay untouched. `overrun` is set.
- R4: A control write keeps only bits 7, 6, 3 and 0 (mask 0xC9) in `fcr_q`. Bit 1 (receive flush) and bit 2 (transmit flush) act once and are never stored.
- R5: A write with bit 2 set, or one that changes bit 0, gives a one-cycle `tx_flush` pulse in the cycle after the write.
- R6: A write with bit 1 set, or one that changes bit 0, empties the receive buffer and the holding byte, and clears the timeout counter and `tmo_pend`.
- R7: In buffered mode, reading an empty buffer returns 0x00. `data_ready` is high exactly while bytes are held. A read that takes the last byte clears `break_det`.
- R8: A received break stores a 0x00 byte and sets both `break_det` and `data_ready`.
- R9: A line-status read (`lsr_rd`) clears `break_det` and `overrun`. A new error in the same cycle wins.
- R10: In buffered mode, with data held and no read or receive, `tmo_pend` rises on the 64*C-th `baud16_tick`, where C is the character length in bits. Any receive or read restarts the count, and any read clears `tmo_pend`.
- R11: C = 1 start bit + (5 + `fmt_wlen`) data bits + `fmt_parity` + (1 or 2 stop bits by `fmt_stop2`). For example 5N1 gives 448 ticks, 8N1 gives 640 and 8E2 gives 768.
- R12: In single-byte mode (bit 0 clear) a receive loads a holding byte and sets `data_ready`, and a read returns that byte and clears `data_ready`. A receive while `data_ready` is still set and no read is made sets `overrun`.
- R13: `rx_ready` is high at all times after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Received byte present |
| rx_ready | output | 1 | Always high; the receiver is never stalled |
| rx_data | input | 8 | Received byte |
| rx_break | input | 1 | The byte marks a break condition |
| rd_en | input | 1 | CPU pops the receive buffer |
| rd_data | output | 8 | Byte returned by a read in this cycle |
| lsr_rd | input | 1 | CPU reads line status (clears error bits) |
| fcr_we | input | 1 | FIFO control write strobe |
| fcr_wdata | input | 8 | FIFO control write value |
| fmt_wlen | input | 2 | Data bits minus 5 |
| fmt_parity | input | 1 | Parity bit present |
| fmt_stop2 | input | 1 | Two stop bits |
| baud16_tick | input | 1 | Enable pulse at 16x baud rate |
| fifo_count | output | 5 | Bytes held in the buffer |
| trig_level | output | 5 | Selected trigger level |
| fcr_q | output | 8 | Retained control bits |
| tx_flush | output | 1 | Pulse that flushes the transmit buffer |
| data_ready | output | 1 | Received data available |
| overrun | output | 1 | Sticky overrun error |
| break_det | output | 1 | Sticky break indication |
| tmo_pend | output | 1 | Character timeout pending |

## Verification
Every registered result (count, status bits, `fcr_q`, `trig_level`, `tmo_pend`) reflects a stimulus from the rising edge that samples it, so it is due one cycle later. `rd_data` is combinational and belongs to the same cycle as `rd_en`, while `tx_flush` is due exactly one cycle after the control write. The bench drives inputs on the falling edge and checks read data before the next rising edge. It compares all registered outputs 1 ns after that edge against a reference model that it advances once per cycle. The timeout is checked both one tick before the 64*C-th idle tick and on it, for three frame formats.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
  localparam int unsigned TICKS_PER_BIT = 16;
  localparam int unsigned CHAR_WINDOW   = 4;
  localparam int unsigned MAX_CHAR_BITS = 12;
  localparam logic [7:0]  FCR_KEEP      = 8'hC9;
  localparam int unsigned FCR_EN_B      = 0;
  localparam int unsigned FCR_RXCLR_B   = 1;
  localparam int unsigned FCR_TXCLR_B   = 2;

  function automatic logic [4:0] trig_of(input logic [1:0] sel);
    case (sel)
      2'b00:   return 5'd1;
      2'b01:   return 5'd4;
      2'b10:   return 5'd8;
      default: return 5'd14;
    endcase
  endfunction

  function automatic logic [3:0] char_bits(input logic [1:0] wlen, input logic par,
                                           input logic stop2);
    return 4'd7 + {2'b00, wlen} + {3'b000, par} + {3'b000, stop2};
  endfunction
endpackage

// File: rtl/uart_rxq_store.sv
module uart_rxq_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head = mem[rd_ptr];
endmodule

// File: rtl/uart_rxq_timer.sv
module uart_rxq_timer #(
  parameter int TW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          restart,
  input  logic          clr_pend,
  input  logic          tick,
  input  logic          armed,
  input  logic [TW-1:0] limit,
  output logic          pend
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else if (flush) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else if (restart) begin
      cnt <= '0;
      if (clr_pend) pend <= 1'b0;
    end else if (tick && armed && !pend) begin
      if (cnt >= limit - TW'(1)) begin
        pend <= 1'b1;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_rxq_fcr.sv
module uart_rxq_fcr
  import uart_rxq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  output logic [7:0] fcr_q,
  output logic       rx_flush,
  output logic       tx_flush_q
);
  logic toggle;
  assign toggle   = wdata[FCR_EN_B] ^ fcr_q[FCR_EN_B];
  assign rx_flush = we & (wdata[FCR_RXCLR_B] | toggle);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcr_q      <= '0;
      tx_flush_q <= 1'b0;
    end else begin
      tx_flush_q <= we & (wdata[FCR_TXCLR_B] | toggle);
      if (we) fcr_q <= wdata & FCR_KEEP;
    end
  end
endmodule

// File: rtl/uart_rxq.sv
module uart_rxq
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rx_valid,
  output logic                         rx_ready,
  input  logic [DW-1:0]                rx_data,
  input  logic                         rx_break,
  input  logic                         rd_en,
  output logic [DW-1:0]                rd_data,
  input  logic                         lsr_rd,
  input  logic                         fcr_we,
  input  logic [7:0]                   fcr_wdata,
  input  logic [1:0]                   fmt_wlen,
  input  logic                         fmt_parity,
  input  logic                         fmt_stop2,
  input  logic                         baud16_tick,
  output logic [$clog2(DEPTH+1)-1:0]   fifo_count,
  output logic [$clog2(DEPTH+1)-1:0]   trig_level,
  output logic [7:0]                   fcr_q,
  output logic                         tx_flush,
  output logic                         data_ready,
  output logic                         overrun,
  output logic                         break_det,
  output logic                         tmo_pend
);
  localparam int CW      = $clog2(DEPTH + 1);
  localparam int MAX_LIM = MAX_CHAR_BITS * TICKS_PER_BIT * CHAR_WINDOW;
  localparam int TW      = $clog2(MAX_LIM + 1);

  logic          fifo_en, rx_flush, full, empty;
  logic          f_push, f_pop, last_pop;
  logic          ov_set, bi_set, bi_clr;
  logic [DW-1:0] head, hold_q, in_byte;
  logic          hold_full;
  logic [TW-1:0] limit;

  uart_rxq_fcr u_fcr (
    .clk(clk), .rst_n(rst_n), .we(fcr_we), .wdata(fcr_wdata),
    .fcr_q(fcr_q), .rx_flush(rx_flush), .tx_flush_q(tx_flush)
  );

  assign fifo_en  = fcr_q[FCR_EN_B];
  assign full     = (fifo_count == CW'(DEPTH));
  assign empty    = (fifo_count == '0);
  assign in_byte  = rx_break ? '0 : rx_data;
  assign f_push   = rx_valid & fifo_en & ~full & ~rx_flush;
  assign f_pop    = rd_en & fifo_en & ~empty;
  assign last_pop = f_pop & (fifo_count == CW'(1)) & ~f_push;

  uart_rxq_store #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush), .push(f_push), .pop(f_pop),
    .wdata(in_byte), .head(head), .count(fifo_count)
  );

  // Single-byte mode holding register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
    end else if (rx_flush) begin
      hold_full <= 1'b0;
    end else if (!fifo_en) begin
      if (rx_valid) begin
        hold_q    <= in_byte;
        hold_full <= 1'b1;
      end else if (rd_en) begin
        hold_full <= 1'b0;
      end
    end
  end

  // Sticky line-status bits: a new event wins over a clear
  assign ov_set = rx_valid & ~rx_flush & (fifo_en ? full : (hold_full & ~rd_en));
  assign bi_set = rx_valid & rx_break & ~rx_flush;
  assign bi_clr = lsr_rd | last_pop | (~fifo_en & rd_en & ~rx_valid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overrun   <= 1'b0;
      break_det <= 1'b0;
    end else begin
      overrun   <= ov_set | (overrun & ~lsr_rd);
      break_det <= bi_set | (break_det & ~bi_clr);
    end
  end

  assign limit = TW'(char_bits(fmt_wlen, fmt_parity, fmt_stop2)) *
                 TW'(TICKS_PER_BIT * CHAR_WINDOW);

  uart_rxq_timer #(.TW(TW)) u_tmo (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush),
    .restart(fifo_en & (rx_valid | rd_en)), .clr_pend(rd_en),
    .tick(baud16_tick), .armed(fifo_en & ~empty), .limit(limit), .pend(tmo_pend)
  );

  assign rx_ready   = 1'b1;
  assign data_ready = fifo_en ? ~empty : hold_full;
  assign rd_data    = fifo_en ? (empty ? '0 : head) : hold_q;
  assign trig_level = CW'(trig_of(fcr_q[7:6]));
endmodule

// File: rtl/uart_rxq_chk.sv
module uart_rxq_chk #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_valid,
  input logic          rx_break,
  input logic          rd_en,
  input logic          lsr_rd,
  input logic          fcr_we,
  input logic [7:0]    fcr_wdata,
  input logic [7:0]    fcr_q,
  input logic [CW-1:0] fifo_count,
  input logic [DW-1:0] rd_data,
  input logic          overrun,
  input logic          break_det,
  input logic          data_ready,
  input logic          tmo_pend,
  input logic          tx_flush
);
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CW'(DEPTH)); // R1
  AST_FULL_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    fcr_q[0] && fifo_count == CW'(DEPTH) && rx_valid && !fcr_we |=> overrun); // R3
  AST_FULL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    fcr_q[0] && fifo_count == CW'(DEPTH) && rx_valid && !rd_en && !fcr_we
    |=> fifo_count == CW'(DEPTH)); // R3
  AST_TOGGLE_TXFLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    fcr_we && (fcr_wdata[0] != fcr_q[0]) |=> tx_flush); // R5
  AST_RXCLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    fcr_we && fcr_wdata[1] |=> fifo_count == '0 && !tmo_pend); // R6
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fcr_q[0] && fifo_count == '0 |-> rd_data == '0); // R7
  AST_BREAK_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_break && !fcr_we |=> break_det && data_ready); // R8
  AST_LSR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    lsr_rd && !rx_valid |=> !overrun && !break_det); // R9
  AST_READ_DROPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !tmo_pend); // R10
  AST_PEND_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_pend |-> fifo_count != '0); // R10
endmodule

bind uart_rxq uart_rxq_chk #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_break(rx_break),
  .rd_en(rd_en), .lsr_rd(lsr_rd), .fcr_we(fcr_we), .fcr_wdata(fcr_wdata),
  .fcr_q(fcr_q), .fifo_count(fifo_count), .rd_data(rd_data), .overrun(overrun),
  .break_det(break_det), .data_ready(data_ready), .tmo_pend(tmo_pend),
  .tx_flush(tx_flush)
);

// File: tb/sim_uart_rxq.sv
module sim_uart_rxq;
  localparam int DEPTH = 16;
  localparam int CW    = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, rx_valid, rx_ready, rx_break, rd_en, lsr_rd, fcr_we;
  logic [7:0]    rx_data, rd_data, fcr_wdata, fcr_q;
  logic [1:0]    fmt_wlen;
  logic          fmt_parity, fmt_stop2, baud16_tick;
  logic [CW-1:0] fifo_count, trig_level;
  logic          tx_flush, data_ready, overrun, break_det, tmo_pend;

  uart_rxq #(.DEPTH(DEPTH), .DW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_break(rx_break), .rd_en(rd_en), .rd_data(rd_data),
    .lsr_rd(lsr_rd), .fcr_we(fcr_we), .fcr_wdata(fcr_wdata), .fmt_wlen(fmt_wlen),
    .fmt_parity(fmt_parity), .fmt_stop2(fmt_stop2), .baud16_tick(baud16_tick),
    .fifo_count(fifo_count), .trig_level(trig_level), .fcr_q(fcr_q),
    .tx_flush(tx_flush), .data_ready(data_ready), .overrun(overrun),
    .break_det(break_det), .tmo_pend(tmo_pend)
  );

  int n_chk = 0;
  int n_bad = 0;

  // Reference model state
  bit [7:0] mq[$];
  bit [7:0] m_fcr, m_hold;
  bit       m_en, m_ov, m_bi, m_hf, m_pend;
  int       m_tcnt;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int charbits();
    return 1 + 5 + int'(fmt_wlen) + int'(fmt_parity) + 1 + int'(fmt_stop2);
  endfunction

  function automatic int trig(bit [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  task automatic check_all();
    chk("R1 count", fifo_count, m_en ? mq.size() : 0);
    chk("R7 data ready", data_ready, m_en ? (mq.size() > 0) : m_hf);
    chk("R3 overrun", overrun, m_ov);
    chk("R8 break", break_det, m_bi);
    chk("R10 timeout pending", tmo_pend, m_pend);
    chk("R2 trigger level", trig_level, trig(m_fcr[7:6]));
    chk("R4 retained fcr", fcr_q, m_fcr);
    chk("R13 ready", rx_ready, 1);
  endtask

  task automatic step(bit rxv, bit [7:0] rxd, bit brk, bit rd, bit lsr, bit tick);
    int  n0;
    bit  full, push, pop, lastpop, ovs, bis, bic;
    @(negedge clk);
    rx_valid = rxv; rx_data = rxd; rx_break = brk; rd_en = rd; lsr_rd = lsr;
    baud16_tick = tick; fcr_we = 1'b0;
    #1;
    if (rd) begin
      if (!m_en)              chk("R12 hold read", rd_data, m_hold);
      else if (mq.size() == 0) chk("R7 empty read", rd_data, 0);
      else                     chk("R1 read order", rd_data, mq[0]);
    end
    n0 = mq.size();
    if (m_en) begin
      full = (n0 == DEPTH); push = rxv && !full; pop = rd && n0 > 0;
      ovs = rxv && full; bis = rxv && brk;
      lastpop = pop && n0 == 1 && !push;
      if (rxv || rd) begin
        m_tcnt = 0;
        if (rd) m_pend = 0;
      end else if (tick && n0 > 0 && !m_pend) begin
        if (m_tcnt >= charbits() * 64 - 1) begin m_pend = 1; m_tcnt = 0; end
        else m_tcnt++;
      end
      if (pop) void'(mq.pop_front());
      if (push) mq.push_back(brk ? 8'h00 : rxd);
      bic = lsr || lastpop;
    end else begin
      ovs = rxv && m_hf && !rd; bis = rxv && brk;
      bic = lsr || (rd && !rxv);
      if (rxv) begin m_hold = brk ? 8'h00 : rxd; m_hf = 1; end
      else if (rd) m_hf = 0;
    end
    m_ov = ovs || (m_ov && !lsr);
    m_bi = bis || (m_bi && !bic);
    @(posedge clk); #1;
    chk("R5 no stray tx flush", tx_flush, 0);
    check_all();
  endtask

  task automatic idle(int n, bit tick);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, tick);
  endtask

  task automatic wfcr(bit [7:0] v);
    bit tog, rxf, txf;
    @(negedge clk);
    fcr_we = 1'b1; fcr_wdata = v; rx_valid = 0; rd_en = 0; lsr_rd = 0; baud16_tick = 0;
    tog = v[0] ^ m_fcr[0]; rxf = v[1] | tog; txf = v[2] | tog;
    if (rxf) begin mq.delete(); m_tcnt = 0; m_pend = 0; m_hf = 0; end
    m_fcr = v & 8'hC9; m_en = m_fcr[0];
    @(posedge clk); #1;
    fcr_we = 1'b0;
    chk("R5 tx flush pulse", tx_flush, txf);
    check_all();
  endtask

  task automatic tmo_case(bit [1:0] w, bit p, bit s, int ticks);
    @(negedge clk);
    fmt_wlen = w; fmt_parity = p; fmt_stop2 = s;
    wfcr(8'h03);
    step(1, 8'hA5, 0, 0, 0, 1);
    idle(ticks - 1, 1);
    chk("R11 no timeout one tick early", tmo_pend, 0);
    idle(1, 1);
    chk("R10 R11 timeout at limit", tmo_pend, 1);
    step(0, 0, 0, 1, 0, 1);
    chk("R10 read clears pending", tmo_pend, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0197));
    rst_n = 0; rx_valid = 0; rx_data = 0; rx_break = 0; rd_en = 0; lsr_rd = 0;
    fcr_we = 0; fcr_wdata = 0; fmt_wlen = 2'd3; fmt_parity = 0; fmt_stop2 = 0;
    baud16_tick = 0;
    m_fcr = 0; m_en = 0; m_ov = 0; m_bi = 0; m_hf = 0; m_hold = 0; m_pend = 0; m_tcnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk("R1 reset count", fifo_count, 0);
    chk("R7 reset data ready", data_ready, 0);
    chk("R2 reset level", trig_level, 1);
    chk("R13 ready after reset", rx_ready, 1);

    // R12 single-byte mode
    step(1, 8'h5A, 0, 0, 0, 0);
    chk("R12 holding ready", data_ready, 1);
    step(0, 0, 0, 1, 0, 0);
    chk("R12 cleared by read", data_ready, 0);
    step(1, 8'h11, 0, 0, 0, 0);
    step(1, 8'h22, 0, 0, 0, 0);
    chk("R12 overrun on unread byte", overrun, 1);
    step(0, 0, 0, 0, 1, 0);
    chk("R9 status read clears overrun", overrun, 0);

    // R4 R5 R2 control register
    wfcr(8'h01);
    wfcr(8'hCF);
    chk("R4 masked value", fcr_q, 8'hC9);
    chk("R2 level for 11", trig_level, 14);
    for (int s = 0; s < 4; s++) begin
      wfcr({s[1:0], 6'b000001});
      chk("R2 level decode", trig_level, trig(s[1:0]));
    end

    // R3 fill and overflow, R1 order, R7 empty read
    for (int i = 0; i < DEPTH; i++) step(1, 8'h30 + i[7:0], 0, 0, 0, 0);
    chk("R1 full count", fifo_count, 16);
    step(1, 8'hEE, 0, 0, 0, 0);
    chk("R3 overrun when full", overrun, 1);
    chk("R3 contents kept", fifo_count, 16);
    for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 1, 1, 0);
    chk("R7 ready low when empty", data_ready, 0);

    // R8 break
    step(1, 8'h77, 1, 0, 0, 0);
    chk("R8 break flag", break_det, 1);
    chk("R8 break data ready", data_ready, 1);
    step(0, 0, 0, 1, 0, 0);
    chk("R7 last read clears break", break_det, 0);

    // R6 receive flush
    step(1, 8'h01, 0, 0, 0, 0);
    step(1, 8'h02, 0, 0, 0, 0);
    wfcr(8'h03);
    chk("R6 flush empties", fifo_count, 0);

    // R10 R11 timeout across frame formats
    tmo_case(2'd0, 0, 0, 448);
    tmo_case(2'd3, 0, 0, 640);
    tmo_case(2'd3, 1, 1, 768);

    // Random buffered traffic with long idle stretches
    wfcr(8'h41);
    for (int i = 0; i < 5000; i++) begin
      bit [31:0] r;
      r = $urandom;
      if (i % 700 == 699) idle(800, 1);
      else step(r[3:0] < 6, r[15:8], r[19:16] == 0, r[23:20] < 5, r[27:24] == 0, r[28]);
      if (i % 1500 == 1499) wfcr({r[30:29], 6'b000001});
    end

    // Random single-byte traffic
    wfcr(8'h00);
    for (int i = 0; i < 1500; i++) begin
      bit [31:0] r;
      r = $urandom;
      step(r[2:0] < 3, r[15:8], r[19:16] == 0, r[22:20] < 3, r[27:24] == 0, r[28]);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule